// File: doc/BRIEF.md
# Hidden Configuration Gate for a Task-File Register Port

This block sits on the target side of a byte/halfword register port with eight offsets. Normally every access goes to an ordinary register file, which is a stub here. A small set of configuration registers stays out of sight until the host performs an exact unlock ritual. That ritual is two halfword reads of offset 1 back to back, then a byte write of 0x03 to offset 2.

Once the gate is open, byte writes to four offsets go to the configuration registers instead:

- offset 0 holds the read-cycle timing;
- offset 1 holds the write-cycle timing;
- offset 3 holds the control value;
- offset 6 holds the miscellaneous value.

A byte write of 0x83 to offset 2 shuts the gate again. Separately, offset 5 is a strap probe. A byte write of 0xFF there arms it, and the next reads of offset 5 return the clock-speed strap in bit 0. That strap is captured from a pin while reset is held. When 0x85 is written to the control register, an override flag is raised to say that programming is complete.

The gate is a four-state machine:

- **LOCKED** moves to **GATE1** on a halfword read of offset 1.
- **GATE1** moves to **GATE2** on a second such read.
- **GATE2** moves to **OPEN** on the key write.
- In **GATE1** or **GATE2**, any other access is a break transition back to **LOCKED**.
- **OPEN** returns to **LOCKED** only on the relock write.
- Idle cycles, with no strobe, leave every state as it is.

Top module: `hidden_cfg_port`

## Requirements
- R1: Two consecutive halfword reads (bus_wide=1) of offset 1 followed by a byte write (bus_wide=0) of low byte 0x03 to offset 2 set `unlocked` to 1 from the cycle after the write; idle cycles between steps are allowed.
- R2: While unlocked, a write to offset 0 loads `cfg_rd_timing` and a write to offset 1 loads `cfg_wr_timing` with bus_wdata[7:0], visible the cycle after the write.
- R3: While unlocked, a write to offset 3 loads `cfg_ctrl` and a write to offset 6 loads `cfg_misc` with bus_wdata[7:0].
- R4: While unlocked, a byte write of low byte 0x83 to offset 2 clears `unlocked` the next cycle and is not stored in the stub.
- R5: A write whose low byte is 0xFF to offset 5 arms the strap probe. While it is armed, any read of offset 5 returns 0x0001 if strap_pin was 1 during the last reset, otherwise 0x0000. A write of any other low byte to offset 5 disarms the probe, and reads then return the stub contents again.
- R6: A configuration write of 0x85 to offset 3 sets `cfg_override`; a configuration write of any other value to offset 3 clears it.
- R7: In GATE1 or GATE2, any access that is not the next step breaks the partial sequence and returns to LOCKED. This includes a byte read of offset 1, a third halfword read, and a wrong key value.
- R8: While locked, reads and writes at every offset reach the stub and all configuration outputs stay unchanged. A halfword write stores 16 bits, a byte write replaces only bits 7:0, and a byte read returns bits 7:0 zero-extended.
- R9: After reset, `unlocked`, `cfg_override`, all configuration registers and all stub entries are zero.
- R10: While unlocked, all reads, and writes to offsets 2 (other than the relock), 4, 5 and 7, reach the stub; configuration writes do not alter the stub.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_pin | input | 1 | Clock-speed strap, captured during reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wide | input | 1 | 1 = halfword access, 0 = byte access |
| bus_ofs | input | 3 | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle bus_rd is high |
| unlocked | output | 1 | 1 while the configuration gate is open |
| cfg_rd_timing | output | CFG_W | Read-cycle timing register |
| cfg_wr_timing | output | CFG_W | Write-cycle timing register |
| cfg_ctrl | output | CFG_W | Control register |
| cfg_misc | output | CFG_W | Miscellaneous register |
| cfg_override | output | 1 | Programming complete, override strap defaults |

## Verification
One write to offset 5 in the middle of an unlock sequence does two things in the same cycle. It is a break transition that drops GATE2 back to LOCKED, and it arms the strap probe in the stub path. The bench provokes this with two gate reads followed by the 0xFF arming write. It then checks that `unlocked` stays low and that the next read of offset 5 returns the strap that was captured at reset, not the live pin. A second coincidence is that the key write itself lands in the stub while it opens the gate. The bench checks this by reading offset 2 back after the gate has been relocked.

// File: rtl/hcfg_pkg.sv
package hcfg_pkg;

    localparam int OFS_W  = 3;
    localparam int KEY_W  = 8;
    localparam int N_CFG  = 4;

    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_GATE1  = 2'd1,
        ST_GATE2  = 2'd2,
        ST_OPEN   = 2'd3
    } gate_state_e;

    // offsets whose position the host software relies on
    localparam logic [OFS_W-1:0] OFS_RDT   = 3'd0;
    localparam logic [OFS_W-1:0] OFS_GATE  = 3'd1;
    localparam logic [OFS_W-1:0] OFS_WRT   = 3'd1;
    localparam logic [OFS_W-1:0] OFS_KEY   = 3'd2;
    localparam logic [OFS_W-1:0] OFS_CTL   = 3'd3;
    localparam logic [OFS_W-1:0] OFS_STRAP = 3'd5;
    localparam logic [OFS_W-1:0] OFS_MISC  = 3'd6;

    localparam logic [KEY_W-1:0] CODE_UNLOCK = 8'h03;
    localparam logic [KEY_W-1:0] CODE_RELOCK = 8'h83;
    localparam logic [KEY_W-1:0] CODE_DONE   = 8'h85;
    localparam logic [KEY_W-1:0] CODE_ARM    = 8'hFF;

    // slot order of the configuration bank
    localparam logic [OFS_W-1:0] CFG_OFS [N_CFG] = '{OFS_RDT, OFS_WRT, OFS_CTL, OFS_MISC};
    localparam int SLOT_CTL = 2;

    function automatic logic is_cfg_ofs(input logic [OFS_W-1:0] o);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < N_CFG; i++) begin
            if (o == CFG_OFS[i]) hit = 1'b1;
        end
        return hit;
    endfunction

endpackage

// File: rtl/hcfg_unlock_fsm.sv
module hcfg_unlock_fsm
    import hcfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_rd,
    input  logic             acc_wr,
    input  logic             acc_wide,
    input  logic [OFS_W-1:0] acc_ofs,
    input  logic [KEY_W-1:0] acc_key,
    output logic             open_o,
    output logic             cfg_we,
    output logic             stub_we
);

    gate_state_e state_q, state_d;

    logic any_acc;
    logic gate_rd;
    logic key_wr;
    logic relock_wr;

    assign any_acc   = acc_rd | acc_wr;
    assign gate_rd   = acc_rd & ~acc_wr & acc_wide & (acc_ofs == OFS_GATE);
    assign key_wr    = acc_wr & ~acc_wide & (acc_ofs == OFS_KEY) & (acc_key == CODE_UNLOCK);
    assign relock_wr = acc_wr & ~acc_wide & (acc_ofs == OFS_KEY) & (acc_key == CODE_RELOCK);

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: begin
                if (gate_rd) state_d = ST_GATE1;
            end
            ST_GATE1: begin
                if (gate_rd)      state_d = ST_GATE2;
                else if (any_acc) state_d = ST_LOCKED;
            end
            ST_GATE2: begin
                if (key_wr)       state_d = ST_OPEN;
                else if (any_acc) state_d = ST_LOCKED;
            end
            ST_OPEN: begin
                if (relock_wr) state_d = ST_LOCKED;
            end
            default: state_d = ST_LOCKED;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    // output decode
    always_comb begin
        open_o  = 1'b0;
        cfg_we  = 1'b0;
        stub_we = acc_wr;
        unique case (state_q)
            ST_OPEN: begin
                open_o  = 1'b1;
                cfg_we  = acc_wr & is_cfg_ofs(acc_ofs);
                stub_we = acc_wr & ~is_cfg_ofs(acc_ofs) & ~relock_wr;
            end
            ST_LOCKED, ST_GATE1, ST_GATE2: begin
                open_o = 1'b0;
            end
            default: begin
                stub_we = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/hcfg_cfg_bank.sv
module hcfg_cfg_bank
    import hcfg_pkg::*;
#(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [OFS_W-1:0] wr_ofs,
    input  logic [CFG_W-1:0] wr_byte,
    output logic [CFG_W-1:0] cfg_q [N_CFG],
    output logic             override_q
);

    localparam logic [CFG_W-1:0] DONE_VAL = CFG_W'(CODE_DONE);

    genvar g;
    generate
        for (g = 0; g < N_CFG; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cfg_q[g] <= '0;
                else if (cfg_we && (wr_ofs == CFG_OFS[g]))
                    cfg_q[g] <= wr_byte;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)
            override_q <= 1'b0;
        else if (cfg_we && (wr_ofs == CFG_OFS[SLOT_CTL]))
            override_q <= (wr_byte == DONE_VAL);
    end

endmodule

// File: rtl/hcfg_stub_file.sv
module hcfg_stub_file
    import hcfg_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_pin,
    input  logic              stub_we,
    input  logic              acc_rd,
    input  logic              acc_wide,
    input  logic [OFS_W-1:0]  acc_ofs,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 2 ** OFS_W;
    localparam int LO_W  = 8;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic              strap_q;
    logic              armed_q;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_ent
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem_q[g] <= '0;
                else if (stub_we && (acc_ofs == OFS_W'(g))) begin
                    if (acc_wide) mem_q[g] <= acc_wdata;
                    else          mem_q[g][LO_W-1:0] <= acc_wdata[LO_W-1:0];
                end
            end
        end
    endgenerate

    // strap captured while reset is held, probe armed by a magic write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_q <= strap_pin;
            armed_q <= 1'b0;
        end else if (stub_we && (acc_ofs == OFS_STRAP)) begin
            armed_q <= (acc_wdata[LO_W-1:0] == CODE_ARM);
        end
    end

    always_comb begin
        rdata = '0;
        if (acc_rd) begin
            if (armed_q && (acc_ofs == OFS_STRAP))
                rdata = {{(DATA_W-1){1'b0}}, strap_q};
            else if (acc_wide)
                rdata = mem_q[acc_ofs];
            else
                rdata = {{(DATA_W-LO_W){1'b0}}, mem_q[acc_ofs][LO_W-1:0]};
        end
    end

endmodule

// File: rtl/hidden_cfg_port.sv
module hidden_cfg_port
    import hcfg_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CFG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_pin,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_wide,
    input  logic [2:0]        bus_ofs,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              unlocked,
    output logic [CFG_W-1:0]  cfg_rd_timing,
    output logic [CFG_W-1:0]  cfg_wr_timing,
    output logic [CFG_W-1:0]  cfg_ctrl,
    output logic [CFG_W-1:0]  cfg_misc,
    output logic              cfg_override
);

    logic             cfg_we;
    logic             stub_we;
    logic [CFG_W-1:0] bank_q [N_CFG];

    hcfg_unlock_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_rd   (bus_rd),
        .acc_wr   (bus_wr),
        .acc_wide (bus_wide),
        .acc_ofs  (bus_ofs),
        .acc_key  (bus_wdata[KEY_W-1:0]),
        .open_o   (unlocked),
        .cfg_we   (cfg_we),
        .stub_we  (stub_we)
    );

    hcfg_cfg_bank #(.CFG_W(CFG_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .wr_ofs     (bus_ofs),
        .wr_byte    (bus_wdata[CFG_W-1:0]),
        .cfg_q      (bank_q),
        .override_q (cfg_override)
    );

    hcfg_stub_file #(.DATA_W(DATA_W)) u_stub (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_pin (strap_pin),
        .stub_we   (stub_we),
        .acc_rd    (bus_rd),
        .acc_wide  (bus_wide),
        .acc_ofs   (bus_ofs),
        .acc_wdata (bus_wdata),
        .rdata     (bus_rdata)
    );

    assign cfg_rd_timing = bank_q[0];
    assign cfg_wr_timing = bank_q[1];
    assign cfg_ctrl      = bank_q[2];
    assign cfg_misc      = bank_q[3];

endmodule

// File: rtl/hidden_cfg_port_chk.sv
module hidden_cfg_port_chk #(
    parameter int CFG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic             bus_wide,
    input logic [2:0]       bus_ofs,
    input logic [7:0]       wd_lo,
    input logic             unlocked,
    input logic [CFG_W-1:0] cfg_rd_timing,
    input logic [CFG_W-1:0] cfg_wr_timing,
    input logic [CFG_W-1:0] cfg_ctrl,
    input logic [CFG_W-1:0] cfg_misc,
    input logic             cfg_override
);

    p_open_after_key_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(bus_wr && !bus_wide && bus_ofs == 3'd2 && wd_lo == 8'h03));

    p_rdt_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && bus_wr && bus_ofs == 3'd0) |=> (cfg_rd_timing == CFG_W'($past(wd_lo))));

    p_misc_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && bus_wr && bus_ofs == 3'd6) |=> (cfg_misc == CFG_W'($past(wd_lo))));

    p_relock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && bus_wr && !bus_wide && bus_ofs == 3'd2 && wd_lo == 8'h83) |=> !unlocked);

    p_done_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && bus_wr && bus_ofs == 3'd3 && wd_lo == 8'h85) |=> cfg_override);

    p_break_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && bus_wr && !(bus_ofs == 3'd2 && !bus_wide && wd_lo == 8'h03)) |=> !unlocked);

    p_locked_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> ($stable(cfg_rd_timing) && $stable(cfg_wr_timing) &&
                       $stable(cfg_ctrl) && $stable(cfg_misc) && $stable(cfg_override)));

endmodule

bind hidden_cfg_port hidden_cfg_port_chk #(.CFG_W(CFG_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_rd        (bus_rd),
    .bus_wr        (bus_wr),
    .bus_wide      (bus_wide),
    .bus_ofs       (bus_ofs),
    .wd_lo         (bus_wdata[7:0]),
    .unlocked      (unlocked),
    .cfg_rd_timing (cfg_rd_timing),
    .cfg_wr_timing (cfg_wr_timing),
    .cfg_ctrl      (cfg_ctrl),
    .cfg_misc      (cfg_misc),
    .cfg_override  (cfg_override)
);

// File: tb/hidden_cfg_port_tb.sv
module hidden_cfg_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_pin = 1'b1;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_wide = 1'b0;
    logic [2:0]  bus_ofs = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        unlocked;
    logic [7:0]  cfg_rd_timing, cfg_wr_timing, cfg_ctrl, cfg_misc;
    logic        cfg_override;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    hidden_cfg_port u_dut (
        .clk(clk), .rst_n(rst_n), .strap_pin(strap_pin),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wide(bus_wide),
        .bus_ofs(bus_ofs), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .unlocked(unlocked), .cfg_rd_timing(cfg_rd_timing),
        .cfg_wr_timing(cfg_wr_timing), .cfg_ctrl(cfg_ctrl),
        .cfg_misc(cfg_misc), .cfg_override(cfg_override)
    );

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic        wide;
        logic [2:0]  ofs;
        logic [15:0] wd;
        logic        chk_rd;
        logic [15:0] exp_rd;
        logic        exp_open;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 1'b1, 3'd1, 16'hABCD, 1'b0, 16'h0000, 1'b0}, // R8 locked write
        '{1'b1, 1'b0, 1'b1, 3'd1, 16'h0000, 1'b1, 16'hABCD, 1'b0}, // R1 gate read 1
        '{1'b1, 1'b0, 1'b1, 3'd1, 16'h0000, 1'b1, 16'hABCD, 1'b0}, // R1 gate read 2
        '{1'b0, 1'b1, 1'b0, 3'd2, 16'h0003, 1'b0, 16'h0000, 1'b1}, // R1 key
        '{1'b0, 1'b1, 1'b0, 3'd0, 16'h005A, 1'b0, 16'h0000, 1'b1}, // R2
        '{1'b0, 1'b1, 1'b0, 3'd1, 16'h0044, 1'b0, 16'h0000, 1'b1}, // R2
        '{1'b0, 1'b1, 1'b0, 3'd3, 16'h0085, 1'b0, 16'h0000, 1'b1}, // R3 R6
        '{1'b0, 1'b1, 1'b0, 3'd6, 16'h0021, 1'b0, 16'h0000, 1'b1}, // R3
        '{1'b1, 1'b0, 1'b1, 3'd1, 16'h0000, 1'b1, 16'hABCD, 1'b1}, // R10 stub untouched
        '{1'b1, 1'b0, 1'b0, 3'd2, 16'h0000, 1'b1, 16'h0003, 1'b1}, // R10 key stored
        '{1'b0, 1'b1, 1'b0, 3'd2, 16'h0083, 1'b0, 16'h0000, 1'b0}, // R4 relock
        '{1'b1, 1'b0, 1'b1, 3'd2, 16'h0000, 1'b1, 16'h0003, 1'b0}  // R4 not stored
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic r, input logic w, input logic wide,
                          input logic [2:0] o, input logic [15:0] d,
                          output logic [15:0] q);
        @(negedge clk);
        bus_rd = r; bus_wr = w; bus_wide = wide; bus_ofs = o; bus_wdata = d;
        #1 q = bus_rdata;
        @(posedge clk);
        #1;
        bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic unlock_seq();
        logic [15:0] q;
        access(1'b1, 1'b0, 1'b1, 3'd1, 16'h0, q);
        access(1'b1, 1'b0, 1'b1, 3'd1, 16'h0, q);
        access(1'b0, 1'b1, 1'b0, 3'd2, 16'h0003, q);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] q;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        strap_pin = 1'b0;  // R5: probe must report the value seen in reset

        // R9 reset state
        @(negedge clk);
        check("R9 unlocked", {15'b0, unlocked}, 16'h0);
        check("R9 cfg", {cfg_rd_timing, cfg_ctrl}, 16'h0);
        check("R9 cfg2", {cfg_wr_timing, cfg_misc}, 16'h0);
        check("R9 override", {15'b0, cfg_override}, 16'h0);
        access(1'b1, 1'b0, 1'b1, 3'd3, 16'h0, q);
        check("R9 stub", q, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i].rd, VEC[i].wr, VEC[i].wide, VEC[i].ofs, VEC[i].wd, q);
            if (VEC[i].chk_rd) check($sformatf("R8/R10 vec%0d rdata", i), q, VEC[i].exp_rd);
            check($sformatf("R1/R4 vec%0d unlocked", i), {15'b0, unlocked}, {15'b0, VEC[i].exp_open});
        end
        check("R2 rd timing", {8'h0, cfg_rd_timing}, 16'h005A);
        check("R2 wr timing", {8'h0, cfg_wr_timing}, 16'h0044);
        check("R3 ctrl", {8'h0, cfg_ctrl}, 16'h0085);
        check("R3 misc", {8'h0, cfg_misc}, 16'h0021);
        check("R6 override set", {15'b0, cfg_override}, 16'h1);

        // R5 strap probe
        access(1'b0, 1'b1, 1'b0, 3'd5, 16'h00FF, q);
        access(1'b1, 1'b0, 1'b1, 3'd5, 16'h0, q);
        check("R5 strap read", q, 16'h0001);
        access(1'b0, 1'b1, 1'b0, 3'd5, 16'h0012, q);
        access(1'b1, 1'b0, 1'b1, 3'd5, 16'h0, q);
        check("R5 disarmed", q, 16'h0012);

        // R7 breaks
        access(1'b1, 1'b0, 1'b1, 3'd1, 16'h0, q);
        access(1'b1, 1'b0, 1'b0, 3'd1, 16'h0, q);
        access(1'b1, 1'b0, 1'b1, 3'd1, 16'h0, q);
        access(1'b0, 1'b1, 1'b0, 3'd2, 16'h0003, q);
        check("R7 byte read break", {15'b0, unlocked}, 16'h0);
        access(1'b1, 1'b0, 1'b1, 3'd1, 16'h0, q);
        access(1'b1, 1'b0, 1'b1, 3'd1, 16'h0, q);
        access(1'b1, 1'b0, 1'b1, 3'd1, 16'h0, q);
        access(1'b0, 1'b1, 1'b0, 3'd2, 16'h0003, q);
        check("R7 third read break", {15'b0, unlocked}, 16'h0);
        access(1'b1, 1'b0, 1'b1, 3'd1, 16'h0, q);
        access(1'b1, 1'b0, 1'b1, 3'd1, 16'h0, q);
        access(1'b0, 1'b1, 1'b0, 3'd2, 16'h0004, q);
        check("R7 wrong key", {15'b0, unlocked}, 16'h0);

        // coincidence: arming write breaks a partial sequence
        access(1'b1, 1'b0, 1'b1, 3'd1, 16'h0, q);
        access(1'b1, 1'b0, 1'b1, 3'd1, 16'h0, q);
        access(1'b0, 1'b1, 1'b0, 3'd5, 16'h00FF, q);
        check("R7 arm breaks", {15'b0, unlocked}, 16'h0);
        access(1'b1, 1'b0, 1'b0, 3'd5, 16'h0, q);
        check("R5 armed byte read", q, 16'h0001);

        // R8 locked writes reach stub only, byte lanes
        access(1'b0, 1'b1, 1'b1, 3'd0, 16'h1234, q);
        access(1'b0, 1'b1, 1'b0, 3'd0, 16'h9977, q);
        access(1'b1, 1'b0, 1'b1, 3'd0, 16'h0, q);
        check("R8 byte lane", q, 16'h1277);
        access(1'b1, 1'b0, 1'b0, 3'd0, 16'h0, q);
        check("R8 byte read", q, 16'h0077);
        check("R8 cfg unchanged", {8'h0, cfg_rd_timing}, 16'h005A);
        access(1'b0, 1'b1, 1'b0, 3'd6, 16'h00EE, q);
        check("R8 misc unchanged", {8'h0, cfg_misc}, 16'h0021);

        // R6 clear, R10 write to offset 4 while open
        unlock_seq();
        check("R1 reopen", {15'b0, unlocked}, 16'h1);
        access(1'b0, 1'b1, 1'b0, 3'd3, 16'h0007, q);
        check("R6 override clear", {15'b0, cfg_override}, 16'h0);
        check("R3 ctrl rewrite", {8'h0, cfg_ctrl}, 16'h0007);
        access(1'b0, 1'b1, 1'b1, 3'd4, 16'hBEEF, q);
        access(1'b1, 1'b0, 1'b1, 3'd4, 16'h0, q);
        check("R10 offset 4 stub", q, 16'hBEEF);
        check("R10 still open", {15'b0, unlocked}, 16'h1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule